// File: doc/BRIEF.md
# Coprocessor Command/Response Interface

This block is the slave-side front end of a coprocessor that never drives the memory bus. The host writes instruction words into a command register. The block keeps only words that carry the escape prefix and this unit's identifier. It then publishes a response code, which the host polls. Through that code the coprocessor asks the host for an operand, reports that it is working, hands back a result, or flags a protocol violation. All data movement runs through the host. The coprocessor only states what it needs next.

The execution core is modelled as a handshake that finishes a programmable number of cycles after it starts. Once any requested operand has been supplied, the host is free and the core runs on by itself. A command word is 16 bits, placed in the low bits of the bus word. Bits [15:12] are the escape prefix, bits [11:9] are the unit identifier, bits [8:6] are the instruction type, and bits [5:0] are free. Within the type field, bit 6 asks for an operand, and a nonzero value in bits [8:7] asks for a result. The register port is word-addressed:

| Address | Register | Access |
|---|---|---|
| 0 | command | write |
| 1 | response | read |
| 2 | operand | write |
| 3 | result | read |

Top module: `cpif_top`

## Requirements
- R1: After reset the response reads 0 (idle), `cp_busy` is low and the result register reads 0.
- R2: A write to address 0 whose bits [15:12] are not 1111 is ignored, and the response is unchanged.
- R3: A write to address 0 whose bits [11:9] differ from parameter CP_ID (default 1) is ignored. From idle the response stays 0, and a command in flight carries on undisturbed.
- R4: An accepted command with bit 6 set sets the response to 2 (operand request). The response holds at 2 until the host writes address 2. That write latches the operand and moves the response to 1. Operand writes in any other state are ignored.
- R5: Execution lasts L = max(lat_cfg, 1) cycles. The response reads 1 and `cp_busy` is high from the accepting clock edge until the edge L cycles later. A command with bit 6 clear starts executing on acceptance, with an operand of 0.
- R6: When execution ends, the response becomes 3 if bits [8:7] are nonzero, and the result is the operand XOR the zero-extended 16-bit command word. Otherwise the response becomes 0.
- R7: A read of address 3 while the response is 3 returns the result, and the response becomes 0 at that clock edge. A read of address 3 in any other state returns the held result and changes nothing.
- R8: A matching command written while the response is 1, 2 or 3 sets the response to 7. The pending work is abandoned: `cp_busy` drops and no result appears. A matching command is accepted normally from response 0 or 7.
- R9: A read of address 1 returns the response code in bits [2:0], with the upper bits zero. Reads of addresses 0 and 2 return 0. The response code is always one of 0, 1, 2, 3 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_cfg | input | LAT_W | Execution latency in cycles; 0 acts as 1 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| cp_busy | output | 1 | Execution core is running |

## Verification
Read data is combinational, so a read shows the state left by the previous clock edge. A command or operand write changes the response seen by a read in the next cycle. A result appears exactly L cycles after the edge that started execution. Collecting a result or raising a violation takes effect on the edge of that access. The bench's reference model moves its state on the same rising edge as the design. Outputs are compared 1 ns after each falling edge, once the new inputs are applied, so every cycle of each of these windows is checked.

// File: rtl/cpif_pkg.sv
// Package: shared response codes and register addresses for the
// coprocessor command/response interface.
package cpif_pkg;

    // Response codes; the state machine state is the code itself.
    typedef enum logic [2:0] {
        RSP_IDLE = 3'd0,
        RSP_BUSY = 3'd1,
        RSP_OPND = 3'd2,
        RSP_RSLT = 3'd3,
        RSP_VIOL = 3'd7
    } rsp_e;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_RSP  = 2'd1;
    localparam logic [1:0] A_OPND = 2'd2;
    localparam logic [1:0] A_RSLT = 2'd3;

    localparam logic [3:0] ESC_PREFIX = 4'hF;
    localparam int         HDR_W      = 10;

endpackage

// File: rtl/cpif_decode.sv
// Module: cpif_decode
// Screens the upper 10 bits of a command word: escape prefix, unit
// identifier and instruction type. Purely combinational.
// Assumes: hdr = command[15:6] (prefix, id, type).
module cpif_decode
    import cpif_pkg::*;
#(
    parameter logic [2:0] CP_ID = 3'd1
) (
    input  logic [HDR_W-1:0] hdr,
    output logic             hit,
    output logic             need_opnd,
    output logic             want_res
);

    logic [3:0] pfx;
    logic [2:0] uid;
    logic [2:0] typ;

    // Split header into its fields and derive the command class.
    always_comb begin
        pfx       = hdr[HDR_W-1 -: 4];
        uid       = hdr[HDR_W-5 -: 3];
        typ       = hdr[2:0];
        hit       = (pfx == ESC_PREFIX) && (uid == CP_ID);
        need_opnd = typ[0];
        want_res  = |typ[2:1];
    end

endmodule

// File: rtl/cpif_core_model.sv
// Module: cpif_core_model
// Stand-in for the execution core: a start pulse runs it for
// max(lat,1) cycles, then done pulses for one cycle. A kill aborts it.
// Assumes: start and kill are not asserted together.
module cpif_core_model #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             kill,
    input  logic [LAT_W-1:0] lat,
    output logic             done,
    output logic             busy
);

    logic [LAT_W-1:0] cnt_q;
    logic             run_q;

    // Count down the remaining execution cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= (lat == '0) ? LAT_W'(1) : lat;
        end else if (kill || done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    // Completion is the last counted cycle.
    always_comb begin
        done = run_q && (cnt_q == LAT_W'(1));
        busy = run_q;
    end

endmodule

// File: rtl/cpif_seq.sv
// Module: cpif_seq
// Response state machine and the command, operand and result registers.
// The state is the response code seen by the host.
// Assumes: one bus access per cycle; hit/need/want are decoded from the
// current write data.
module cpif_seq
    import cpif_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              hit,
    input  logic              need_opnd,
    input  logic              want_res,
    input  logic              core_done,
    output rsp_e              state,
    output logic              core_start,
    output logic              core_kill,
    output logic [DATA_W-1:0] res_q
);

    localparam int PAD_W = DATA_W - CMD_W;

    rsp_e              nxt;
    logic [CMD_W-1:0]  cmd_q;
    logic              want_q;
    logic [DATA_W-1:0] opnd_q;
    logic              cmd_wr;
    logic              op_wr;
    logic              res_rd;
    logic              in_flight;
    logic              finish;

    // Classify the current bus access.
    always_comb begin
        cmd_wr    = bus_wr && (bus_addr == A_CMD) && hit;
        op_wr     = bus_wr && (bus_addr == A_OPND) && (state == RSP_OPND);
        res_rd    = bus_rd && (bus_addr == A_RSLT) && (state == RSP_RSLT);
        in_flight = (state == RSP_BUSY) || (state == RSP_OPND) || (state == RSP_RSLT);
        finish    = (state == RSP_BUSY) && core_done && !cmd_wr;
    end

    // Next response state and core handshake.
    always_comb begin
        nxt        = state;
        core_start = 1'b0;
        core_kill  = 1'b0;
        if (cmd_wr && in_flight) begin
            nxt       = RSP_VIOL;
            core_kill = 1'b1;
        end else if (cmd_wr) begin
            nxt        = need_opnd ? RSP_OPND : RSP_BUSY;
            core_start = !need_opnd;
        end else if (op_wr) begin
            nxt        = RSP_BUSY;
            core_start = 1'b1;
        end else if (finish) begin
            nxt = want_q ? RSP_RSLT : RSP_IDLE;
        end else if (res_rd) begin
            nxt = RSP_IDLE;
        end
    end

    // Response state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= nxt;
    end

    // Command, operand and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            want_q <= 1'b0;
            opnd_q <= '0;
            res_q  <= '0;
        end else begin
            if (cmd_wr && !in_flight) begin
                cmd_q  <= bus_wdata[CMD_W-1:0];
                want_q <= want_res;
                opnd_q <= '0;
            end else if (op_wr) begin
                opnd_q <= bus_wdata;
            end
            if (finish && want_q)
                res_q <= opnd_q ^ {{PAD_W{1'b0}}, cmd_q};
        end
    end

endmodule

// File: rtl/cpif_top.sv
// Module: cpif_top
// Coprocessor command/response interface: register port, decoder,
// response sequencer and latency model of the execution core.
// Assumes: CMD_W = 16 < DATA_W; reads are combinational.
module cpif_top
    import cpif_pkg::*;
#(
    parameter int         DATA_W = 32,
    parameter int         CMD_W  = 16,
    parameter int         LAT_W  = 8,
    parameter logic [2:0] CP_ID  = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  lat_cfg,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cp_busy
);

    logic              hit;
    logic              need_opnd;
    logic              want_res;
    logic              core_done;
    logic              core_start;
    logic              core_kill;
    rsp_e              state;
    logic [2:0]        rsp_code;
    logic [DATA_W-1:0] res_q;

    cpif_decode #(.CP_ID(CP_ID)) u_dec (
        .hdr       (bus_wdata[CMD_W-1 -: HDR_W]),
        .hit       (hit),
        .need_opnd (need_opnd),
        .want_res  (want_res)
    );

    cpif_seq #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hit        (hit),
        .need_opnd  (need_opnd),
        .want_res   (want_res),
        .core_done  (core_done),
        .state      (state),
        .core_start (core_start),
        .core_kill  (core_kill),
        .res_q      (res_q)
    );

    cpif_core_model #(.LAT_W(LAT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (core_start),
        .kill  (core_kill),
        .lat   (lat_cfg),
        .done  (core_done),
        .busy  (cp_busy)
    );

    // Read multiplexer over the host-visible registers.
    always_comb begin
        rsp_code  = state;
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_RSP:   bus_rdata = {{(DATA_W-3){1'b0}}, rsp_code};
                A_RSLT:  bus_rdata = res_q;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cpif_checks.sv
// Module: cpif_checks
// Protocol checker for cpif_top, attached by bind. Decodes the written
// header on its own and relates it to the response code and core state.
module cpif_checks #(
    parameter logic [2:0] CP_ID = 3'd1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [6:0] cmd_hdr,
    input logic [2:0] rsp_code,
    input logic       cp_busy
);

    logic esc;
    logic mine;
    logic cmd_w;

    // Independent view of the header being written.
    always_comb begin
        esc   = (cmd_hdr[6:3] == 4'b1111);
        mine  = (cmd_hdr[2:0] == CP_ID);
        cmd_w = bus_wr && (bus_addr == 2'd0);
    end

    assert_drop_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !esc && rsp_code == 3'd0) |=> (rsp_code == 3'd0));

    assert_drop_foreign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && esc && !mine && rsp_code == 3'd0) |=> (rsp_code == 3'd0));

    assert_opnd_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 3'd2 && !(bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd2)))
        |=> (rsp_code == 3'd2));

    assert_busy_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cp_busy == (rsp_code == 3'd1));

    assert_result_from_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 3'd3 && $past(rsp_code) != 3'd3) |-> ($past(rsp_code) == 3'd1));

    assert_collect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code == 3'd3 && bus_rd && !bus_wr && bus_addr == 2'd3) |=> (rsp_code == 3'd0));

    assert_violation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && esc && mine && (rsp_code == 3'd1 || rsp_code == 3'd2 || rsp_code == 3'd3))
        |=> (rsp_code == 3'd7 && !cp_busy));

    assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7});

endmodule

bind cpif_top cpif_checks #(.CP_ID(CP_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .cmd_hdr  (bus_wdata[CMD_W-1 -: 7]),
    .rsp_code (rsp_code),
    .cp_busy  (cp_busy)
);

// File: tb/cpif_top_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge,
// compared against the design one nanosecond after each falling edge.
module cpif_top_tb;

    localparam logic [2:0] CPID = 3'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lat = 8'd3;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur = "R1";

    int          m_st;
    int          m_cnt;
    logic [15:0] m_cmd;
    logic [31:0] m_op;
    logic [31:0] m_res;
    bit          m_want;

    always #2 clk = ~clk;

    cpif_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_cfg   (lat),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .cp_busy   (busy)
    );

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        bit match;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cmd = 0; m_op = 0; m_res = 0; m_want = 0;
        end else begin
            match = wr && addr == 2'd0 && wdata[15:12] == 4'hF && wdata[11:9] == CPID;
            if (match && (m_st == 1 || m_st == 2 || m_st == 3)) begin
                m_st = 7;
            end else if (match) begin
                m_cmd = wdata[15:0]; m_want = (wdata[8:7] != 2'b00); m_op = 0;
                if (wdata[6]) m_st = 2;
                else begin m_st = 1; m_cnt = (lat == 0) ? 1 : lat; end
            end else if (m_st == 2 && wr && addr == 2'd2) begin
                m_op = wdata; m_st = 1; m_cnt = (lat == 0) ? 1 : lat;
            end else if (m_st == 1) begin
                if (m_cnt == 1) begin
                    if (m_want) begin m_res = m_op ^ {16'h0, m_cmd}; m_st = 3; end
                    else m_st = 0;
                end else m_cnt = m_cnt - 1;
            end else if (m_st == 3 && rd && addr == 2'd3) begin
                m_st = 0;
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!rd) return 32'h0;
        if (addr == 2'd1) return 32'(m_st);
        if (addr == 2'd3) return m_res;
        return 32'h0;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur, what, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, compare, wait for the edge.
    task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d;
        #1;
        if (rst_n) begin
            check("cp_busy", {31'h0, busy}, {31'h0, (m_st == 1)});
            if (r) check("rdata", rdata, exp_rdata());
        end
        @(posedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [2:0] id, input logic [2:0] ty, input logic [5:0] ex);
        return {16'hC3C3, 4'hF, id, ty, ex};
    endfunction

    task automatic wcmd(input logic [2:0] id, input logic [2:0] ty, input logic [5:0] ex);
        cyc(1'b1, 1'b0, 2'd0, mk(id, ty, ex));
    endtask

    task automatic wop(input logic [31:0] d);
        cyc(1'b1, 1'b0, 2'd2, d);
    endtask

    task automatic rresp(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 2'd1, 32'h0);
    endtask

    task automatic rres();
        cyc(1'b0, 1'b1, 2'd3, 32'h0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0);
        rst_n = 1'b1;
        cur = "R1"; rresp(1); rres();
        cur = "R9"; cyc(1'b0, 1'b1, 2'd0, 32'h0); cyc(1'b0, 1'b1, 2'd2, 32'h0);
        cur = "R2"; cyc(1'b1, 1'b0, 2'd0, 32'h0000_7240); rresp(2);
        cyc(1'b1, 1'b0, 2'd0, 32'h0000_E2C0); rresp(1);
        cur = "R3"; wcmd(3'd2, 3'd3, 6'd5); rresp(2); wcmd(3'd0, 3'd0, 6'd0); rresp(1);
        cur = "R4"; wop(32'h1234_5678); rresp(1);
        wcmd(CPID, 3'd3, 6'h15); rresp(3); wop(32'hA5A5_0F0F);
        cur = "R5"; rresp(4);
        cur = "R7"; rres(); rresp(1); rres(); rresp(1);
        cur = "R6"; wcmd(CPID, 3'd0, 6'd9); rresp(5);
        cur = "R5"; lat = 8'd0; wcmd(CPID, 3'd2, 6'h2A); rresp(3);
        cur = "R6"; rres();
        lat = 8'd7; wcmd(CPID, 3'd4, 6'd1); rresp(9);
        cur = "R7"; rres(); rresp(1);
        cur = "R8"; lat = 8'd3;
        wcmd(CPID, 3'd1, 6'd0); rresp(1); wcmd(CPID, 3'd0, 6'd0); rresp(2);
        wop(32'h0000_0005); rresp(2);
        wcmd(CPID, 3'd2, 6'd3); rresp(1); wcmd(CPID, 3'd2, 6'd3); rresp(5); rres();
        wcmd(CPID, 3'd2, 6'd4); rresp(4); wcmd(CPID, 3'd0, 6'd0); rresp(1);
        cur = "R3"; wcmd(CPID, 3'd0, 6'd0); wcmd(3'd5, 3'd0, 6'd0); rresp(4);
        finished = 1'b1;
        report();
    end

endmodule